// File: doc/BRIEF.md
# Sliding Hilbert transform engine

This block turns a stream of signed fixed-point samples into an analytic signal. The real part is the input delayed by N samples. The imaginary part is the discrete Hilbert transform of the input, produced by a recursive update over a sliding window of N samples with a hop of one sample. For every accepted sample the engine forms the difference between the new sample and the sample it pushes out of the window. It then walks its N-entry state vector from index 0 upward, one index per clock. Each entry takes the previous value of the entry above it. Even entries also add the difference scaled by a cotangent coefficient from a small constant table. A single multiplier serves all of these steps.

The sample that leaves the ring buffer is exactly the input from N acceptances ago, so the ring buffer also serves as the matched delay for the real part. The two outputs are presented together with a one-cycle valid pulse. A new sample is taken only when the engine is idle. Results carry history only once N samples have been accepted since reset.

Top module: `hilbert_slide`

## Requirements
- R1: Reset (rst_n low) clears the window, the state vector and the outputs: out_valid, out_re and out_im read 0, and in_ready is high within three clock edges after rst_n rises. Samples sent after a reset see an all-zero history.
- R2: A sample is taken only on a rising edge where in_valid and in_ready are both high. Values driven while in_ready is low have no effect on any later output.
- R3: After an accepting edge, in_ready is low until out_valid rises. out_valid is high for exactly one cycle, starting N rising edges after the accepting edge, and in_ready is high again in that cycle.
- R4: out_re equals the sample accepted N acceptances earlier, or 0 if fewer than N samples have been accepted since reset.
- R5: The difference term is the new sample minus the oldest window sample, kept at W+1 bits so that it never wraps.
- R6: In each update, state entry m takes the previous value of entry m+1, and entry N-1 takes 0. Odd entries receive no other change.
- R7: Even entry m also adds the difference times coefficient c(m) = round(2/N * cot(pi*(m+1)/N) * 2^(CW-1)). Rounding is to nearest, with halves away from zero, and the result is held as a CW-bit signed value.
- R8: The product is rounded by adding 2^(CW-2) and shifting arithmetically right by CW-1. It is then saturated to W signed bits. The sum with the shifted entry is also saturated to W signed bits.
- R9: out_im equals state entry 0 after the update for that sample has completed.
- R10: out_re and out_im hold their values in every cycle where out_valid is low.
- R11: Full-scale inputs that alternate between the most positive and most negative W-bit values produce saturated results and never wrapped ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input sample is offered |
| in_data | input | W | Signed input sample |
| in_ready | output | 1 | Engine is idle and will take a sample |
| out_valid | output | 1 | One-cycle pulse: outputs hold a new result |
| out_re | output | W | Real part: input delayed by N samples |
| out_im | output | W | Imaginary part: Hilbert transform value |

## Verification
The bound checker watches the handshake and output rules on every cycle. It confirms that the valid pulse lasts one cycle, that in_ready drops after an acceptance and is back when the result appears, that the window pointer moves only on an accepting edge, and that both outputs hold between pulses. The arithmetic can only be shown by the bench's scenarios, against a reference recursion built from the requirements. These scenarios cover the coefficient values, the rounding and saturation, the N-cycle latency, the N-sample delay of the real part, the clearing of history by a mid-stream reset, and the fact that samples offered while busy have no effect.

// File: rtl/hil_pkg.sv
package hil_pkg;

  typedef enum logic {
    CTL_IDLE = 1'b0,
    CTL_RUN  = 1'b1
  } ctl_e;

  // Clamp a signed value into the range of a w-bit signed number.
  function automatic logic signed [63:0] clip(input logic signed [63:0] v,
                                              input int unsigned w);
    logic signed [63:0] hi;
    logic signed [63:0] lo;
    hi = (64'sd1 <<< (w - 1)) - 64'sd1;
    lo = -(64'sd1 <<< (w - 1));
    if (v > hi)      return hi;
    else if (v < lo) return lo;
    else             return v;
  endfunction

endpackage

// File: rtl/hil_window.sv
// Ring buffer of the last N samples; the entry under the pointer is the oldest.
module hil_window #(
  parameter int N = 128,
  parameter int W = 26,
  localparam int AW = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push,
  input  logic signed [W-1:0] din,
  output logic signed [W-1:0] oldest,
  output logic [AW-1:0]       ptr
);

  logic signed [W-1:0] cell_q [N];
  logic [AW-1:0]       ptr_n;

  always_comb begin
    ptr_n = ptr;
    if (push) ptr_n = (ptr == AW'(N - 1)) ? '0 : ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
      for (int i = 0; i < N; i++) cell_q[i] <= '0;
    end else begin
      ptr <= ptr_n;
      if (push) cell_q[ptr] <= din;
    end
  end

  assign oldest = cell_q[ptr];

endmodule

// File: rtl/hil_state.sv
// N-entry vector of Hilbert terms, rewritten one index per enabled cycle.
module hil_state #(
  parameter int N = 128,
  parameter int W = 26,
  localparam int AW = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [AW-1:0]       idx,
  input  logic signed [W-1:0] wdata,
  output logic signed [W-1:0] above,
  output logic signed [W-1:0] head
);

  logic signed [W-1:0] cell_q [N];

  // Entry beyond the top of the vector reads as zero.
  always_comb begin
    if (idx == AW'(N - 1)) above = '0;
    else                   above = cell_q[idx + 1'b1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) cell_q[i] <= '0;
    end else if (wr_en) begin
      cell_q[idx] <= wdata;
    end
  end

  assign head = cell_q[0];

endmodule

// File: rtl/hil_coef_rom.sv
// Cotangent weights for the even state indices, computed at elaboration.
module hil_coef_rom #(
  parameter int N  = 128,
  parameter int CW = 18,
  localparam int HW = $clog2(N / 2)
) (
  input  logic [HW-1:0]        addr,
  output logic signed [CW-1:0] coef
);

  localparam real PI    = 3.14159265358979323846;
  localparam real SCALE = 2.0 ** (CW - 1);

  logic signed [CW-1:0] tbl [N/2];

  for (genvar k = 0; k < N / 2; k++) begin : g_ent
    localparam real ANG = PI * real'(2 * k + 1) / real'(N);
    localparam real VAL = 2.0 / real'(N) * $cos(ANG) / $sin(ANG) * SCALE;
    localparam int  IV  = (VAL >= 0.0) ? $rtoi(VAL + 0.5) : -$rtoi(0.5 - VAL);
    assign tbl[k] = IV[CW-1:0];
  end

  assign coef = tbl[addr];

endmodule

// File: rtl/hil_mac.sv
// Shared multiply, round, saturate and accumulate step.
module hil_mac #(
  parameter int W  = 26,
  parameter int CW = 18
) (
  input  logic signed [W:0]    diff,
  input  logic signed [CW-1:0] coef,
  input  logic signed [W-1:0]  base,
  input  logic                 corr_en,
  output logic signed [W-1:0]  result
);

  import hil_pkg::*;

  logic signed [63:0] prod;
  logic signed [63:0] term;
  logic signed [63:0] acc;

  always_comb begin
    prod   = $signed(64'(diff)) * $signed(64'(coef));
    term   = clip((prod + (64'sd1 <<< (CW - 2))) >>> (CW - 1), W);
    acc    = $signed(64'(base)) + (corr_en ? term : 64'sd0);
    result = W'(clip(acc, W));
  end

endmodule

// File: rtl/hilbert_slide.sv
module hilbert_slide #(
  parameter int N  = 128,
  parameter int W  = 26,
  parameter int CW = 18,
  localparam int AW = $clog2(N),
  localparam int HW = AW - 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_data,
  output logic                in_ready,
  output logic                out_valid,
  output logic signed [W-1:0] out_re,
  output logic signed [W-1:0] out_im
);

  import hil_pkg::*;

  // Reset: asserted at once, released after two clock edges.
  logic [1:0] rs_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  ctl_e                ctl_q, ctl_n;
  logic [AW-1:0]       cnt_q, cnt_n;
  logic signed [W:0]   diff_q, diff_n;
  logic signed [W-1:0] re_q, re_n;
  logic                ov_q, ov_n;
  logic signed [W-1:0] ore_q, ore_n;
  logic signed [W-1:0] oim_q, oim_n;

  logic                push, st_wr, accept;
  logic signed [W-1:0] oldest, above, head, upd;
  logic signed [CW-1:0] coef;
  logic [AW-1:0]       win_ptr;

  assign in_ready = (ctl_q == CTL_IDLE) & srst_n;
  assign accept   = in_valid & in_ready;

  hil_window #(.N(N), .W(W)) u_win (
    .clk(clk), .rst_n(srst_n), .push(push), .din(in_data),
    .oldest(oldest), .ptr(win_ptr)
  );

  hil_state #(.N(N), .W(W)) u_st (
    .clk(clk), .rst_n(srst_n), .wr_en(st_wr), .idx(cnt_q),
    .wdata(upd), .above(above), .head(head)
  );

  hil_coef_rom #(.N(N), .CW(CW)) u_rom (
    .addr(cnt_q[AW-1:1]), .coef(coef)
  );

  hil_mac #(.W(W), .CW(CW)) u_mac (
    .diff(diff_q), .coef(coef), .base(above), .corr_en(~cnt_q[0]),
    .result(upd)
  );

  always_comb begin
    ctl_n  = ctl_q;
    cnt_n  = cnt_q;
    diff_n = diff_q;
    re_n   = re_q;
    ov_n   = 1'b0;
    ore_n  = ore_q;
    oim_n  = oim_q;
    push   = 1'b0;
    st_wr  = 1'b0;
    unique case (ctl_q)
      CTL_IDLE: begin
        if (accept) begin
          push   = 1'b1;
          ctl_n  = CTL_RUN;
          cnt_n  = '0;
          diff_n = {in_data[W-1], in_data} - {oldest[W-1], oldest};
          re_n   = oldest;
        end
      end
      CTL_RUN: begin
        st_wr = 1'b1;
        if (cnt_q == AW'(N - 1)) begin
          ctl_n = CTL_IDLE;
          ov_n  = 1'b1;
          ore_n = re_q;
          oim_n = head;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      default: ctl_n = CTL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ctl_q  <= CTL_IDLE;
      cnt_q  <= '0;
      diff_q <= '0;
      re_q   <= '0;
      ov_q   <= 1'b0;
      ore_q  <= '0;
      oim_q  <= '0;
    end else begin
      ctl_q  <= ctl_n;
      cnt_q  <= cnt_n;
      diff_q <= diff_n;
      re_q   <= re_n;
      ov_q   <= ov_n;
      ore_q  <= ore_n;
      oim_q  <= oim_n;
    end
  end

  assign out_valid = ov_q;
  assign out_re    = ore_q;
  assign out_im    = oim_q;

endmodule

// File: rtl/hil_sva.sv
module hil_sva #(
  parameter int W  = 26,
  parameter int AW = 7
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic                out_valid,
  input logic signed [W-1:0] out_re,
  input logic signed [W-1:0] out_im,
  input logic [AW-1:0]       win_ptr
);

  // R3: result pulse lasts one cycle
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R3: engine goes busy after taking a sample
  a_r3_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R3: engine is idle again when a result appears
  a_r3_ready_at_result: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);

  // R2: window does not move without an accepting edge
  a_r2_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(win_ptr));

  // R2: window moves on an accepting edge
  a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (win_ptr != $past(win_ptr)));

  // R10: outputs held between pulses
  a_r10_hold_re: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_re));

  a_r10_hold_im: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_im));

endmodule

bind hilbert_slide hil_sva #(.W(W), .AW(AW)) u_sva (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_re(out_re), .out_im(out_im), .win_ptr(win_ptr)
);

// File: tb/tb_hilbert_slide.sv
module tb_hilbert_slide;

  localparam int N  = 128;
  localparam int W  = 26;
  localparam int CW = 18;
  localparam int CLK_PERIOD = 10;
  localparam longint WDOG = 190000;

  logic                clk;
  logic                rst_n;
  logic                in_valid;
  logic signed [W-1:0] in_data;
  logic                in_ready;
  logic                out_valid;
  logic signed [W-1:0] out_re;
  logic signed [W-1:0] out_im;

  hilbert_slide #(.N(N), .W(W), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  typedef struct {
    longint re;
    longint im;
    longint at;
    string  tag;
  } exp_t;
  exp_t sb[$];

  // reference model state
  longint win[N];
  longint stv[N];
  longint cf[N/2];
  int     wp;
  string  im_tag = "R5/R6/R7/R8/R9";

  function automatic longint clipw(longint v);
    longint hi = (longint'(1) <<< (W - 1)) - 1;
    longint lo = -(longint'(1) <<< (W - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      win[i] = 0;
      stv[i] = 0;
    end
    wp = 0;
  endtask

  // R7: coefficient values from the cotangent formula
  task automatic build_coef();
    real pi = 3.14159265358979323846;
    for (int k = 0; k < N / 2; k++) begin
      real a = pi * real'(2 * k + 1) / real'(N);
      real v = 2.0 / real'(N) * $cos(a) / $sin(a) * (2.0 ** (CW - 1));
      cf[k] = (v >= 0.0) ? longint'($rtoi(v + 0.5)) : -longint'($rtoi(0.5 - v));
    end
  endtask

  // Driver: offers one sample, predicts the result, pushes it to the scoreboard.
  task automatic send(longint x, bit junk);
    longint old, y, above, p, t;
    longint nst[N];
    exp_t e;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = W'(x);
    old = win[wp];
    y   = x - old;                                   // R5
    for (int m = 0; m < N; m++) begin
      above = (m == N - 1) ? 0 : stv[m + 1];          // R6
      if (m % 2 == 0) begin
        p = y * cf[m / 2];                            // R7
        t = clipw((p + (longint'(1) <<< (CW - 2))) >>> (CW - 1)); // R8
        nst[m] = clipw(above + t);
      end else begin
        nst[m] = above;
      end
    end
    for (int m = 0; m < N; m++) stv[m] = nst[m];
    win[wp] = x;
    wp = (wp + 1) % N;
    e.re  = old;                                      // R4
    e.im  = stv[0];                                   // R9
    e.at  = cyc + 1 + N;                              // R3
    e.tag = im_tag;
    sb.push_back(e);
    @(negedge clk);
    check(in_ready == 1'b0, "R3", "in_ready after accept", longint'(in_ready), 0);
    if (junk) begin
      // R2: offers made while busy must be ignored
      for (int j = 0; j < N - 6; j++) begin
        in_valid = 1'b1;
        in_data  = W'($urandom);
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
    in_data  = '0;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: pops expectations as results appear.
  logic signed [W-1:0] last_re = '0;
  logic signed [W-1:0] last_im = '0;
  bit prev_ov = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      last_re = '0;
      last_im = '0;
      prev_ov = 0;
    end else if (!done) begin
      if (out_valid) begin
        check(!prev_ov, "R3", "out_valid width", 2, 1);
        if (sb.size() == 0) begin
          check(0, "R3", "unexpected out_valid", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(cyc == e.at, "R3", "latency edge", cyc, e.at);
          check(longint'(out_re) == e.re, "R4", "real part", longint'(out_re), e.re);
          check(longint'(out_im) == e.im, e.tag, "imag part", longint'(out_im), e.im);
          check(in_ready == 1'b1, "R3", "in_ready with result", longint'(in_ready), 1);
        end
        last_re = out_re;
        last_im = out_im;
      end else begin
        check(out_re == last_re, "R10", "out_re held", longint'(out_re), longint'(last_re));
        check(out_im == last_im, "R10", "out_im held", longint'(out_im), longint'(last_im));
      end
      prev_ov = out_valid;
    end
  end

  task automatic summary();
    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // Watchdog
  initial begin
    wait (cyc >= WDOG);
    if (!done) begin
      check(0, "R3", "watchdog expired", cyc, WDOG);
      summary();
    end
  end

  initial begin
    longint fmax = (longint'(1) <<< (W - 1)) - 1;
    longint fmin = -(longint'(1) <<< (W - 1));
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    build_coef();
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1", "out_valid in reset", longint'(out_valid), 0);
    check(out_re == '0, "R1", "out_re in reset", longint'(out_re), 0);
    check(out_im == '0, "R1", "out_im in reset", longint'(out_im), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R1", "in_ready after reset", longint'(in_ready), 1);

    // impulse, then zeros long enough to flush it through both outputs
    send(longint'(1) <<< 20, 0);
    for (int i = 0; i < 2 * N + 2; i++) send(0, 0);

    // sinusoid
    for (int i = 0; i < 160; i++)
      send(longint'($rtoi(16000000.0 * $sin(2.0 * 3.14159265358979 * 5.0 * real'(i) / real'(N)))), 0);

    // R2: junk offered while busy
    im_tag = "R2";
    for (int i = 0; i < 4; i++) send(longint'(i * 700000 - 900000), 1);
    im_tag = "R5/R6/R7/R8/R9";

    // R11: full-scale alternation drives saturation
    im_tag = "R8/R11";
    for (int i = 0; i < 40; i++) send((i % 2 == 0) ? fmax : fmin, 0);
    im_tag = "R5/R6/R7/R8/R9";

    // R1: mid-stream reset clears all history
    drain();
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    @(negedge clk);
    check(out_re == '0, "R1", "out_re after mid reset", longint'(out_re), 0);
    check(out_im == '0, "R1", "out_im after mid reset", longint'(out_im), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R1", "in_ready after mid reset", longint'(in_ready), 1);
    im_tag = "R1/R9";
    send(5000, 0);
    for (int i = 0; i < N + 2; i++) send(0, 0);
    im_tag = "R5/R6/R7/R8/R9";

    // random full-range samples
    for (int i = 0; i < 120; i++)
      send(longint'($urandom_range(0, (1 << W) - 1)) - (longint'(1) <<< (W - 1)), 0);

    drain();
    summary();
  end

endmodule